// File: doc/BRIEF.md
# Multiplexed bus cycle sequencer

This block is the processor-side bus master for a minimum-mode system whose low eight address lines double as the data lines. The top four address lines double as status lines. An internal core hands it one request at a time. A request carries a 20-bit address, a direction, a memory-or-I/O select, a two-bit segment tag and, for writes, one data byte. The block turns that request into a four-state bus cycle. In the first state the complete address goes out with an address-latch strobe, so that external latches can hold it. In the second state the multiplexed lines change over to data and status. The read or write strobe and the data-buffer enable go active. The cycle stretches with wait states for as long as the memory or device holds READY low. The last state releases the strobes and hands the result back to the core.

The block also lets an external DMA master take the bus. A hold request lets any running cycle finish. The bus then goes quiet and a hold acknowledge is raised. The raw reset input is filtered, so a pulse shorter than four clocks does nothing. The block also reports the physical address of the first access after reset, built from the reset segment and offset values (segment times sixteen plus offset).

Top module: `mux_bus_seq`

## Requirements
- R1: The reset input takes effect only after it is high on 4 consecutive rising edges; shorter pulses leave all outputs and state untouched. While reset is in effect, ale=0, rd_n=1, wr_n=1, den_n=1, ad_oe=0, hlda=0, req_ready=0 and done=0.
- R2: boot_addr equals reset segment * 16 + reset offset, which is 20'hFFFF0 for the default segment FFFFh and offset 0000h.
- R3: A request is accepted on a rising edge where req_valid and req_ready are both 1. In the following state (T1), ale=1 and ad_oe=1; ad_out carries address bits 7:0, a_mid carries bits 15:8 and a_top carries bits 19:16.
- R4: io_m equals the request's I/O select (1 = I/O, 0 = memory) from T1 through T4 and is 0 when no cycle is running.
- R5: For a read, rd_n is 0 from T2 until the end of the last T3 or wait state, ad_oe is 0 in that span, and dt_r is 0 for the whole cycle.
- R6: For a write, wr_n is 0 from T2 until the end of the last T3 or wait state, ad_out carries the write byte with ad_oe=1 from T2 through T4, and dt_r is 1 for the whole cycle.
- R7: rd_n and wr_n are never 0 together, and den_n is 0 exactly when one of them is 0.
- R8: From T2 through T4, a_top carries status {1'b0, 1'b0, seg[1:0]}, where seg is the request's segment tag.
- R9: READY is sampled at the rising edge that ends T3 and at each edge that ends a wait state. While it is sampled 0, the strobes stay asserted and done stays 0.
- R10: Read data on ad_in is captured at the edge that leaves the last T3 or wait state. It appears on rdata while done is 1 for exactly one cycle, in T4. Writes also give the one-cycle done pulse.
- R11: While hold_in is 1, a running cycle completes. The block then enters hold: hlda=1, req_ready=0, ad_oe=0, ale=0 and all strobes are inactive. A hold request wins over a request that is pending at the same edge while the bus is idle. Dropping hold_in returns the block to idle one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Raw active-high reset, filtered to a 4-cycle minimum |
| hold_in | input | 1 | Bus hold request from a DMA master |
| ready_in | input | 1 | Slave ready; 0 inserts wait states |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_seg | input | 2 | Segment tag shown in the status bits |
| req_addr | input | 20 | Physical address |
| req_wdata | input | 8 | Write byte |
| ad_in | input | 8 | Multiplexed lines as seen from the pads |
| req_ready | output | 1 | Block can accept a request this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read byte |
| boot_addr | output | 20 | Physical address of the first access after reset |
| ale | output | 1 | Address latch strobe, active high |
| io_m | output | 1 | 1 = I/O access, 0 = memory access |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dt_r | output | 1 | Data direction, 1 = outward, 0 = inward |
| den_n | output | 1 | Data buffer enable, active low |
| hlda | output | 1 | Hold acknowledge, active high |
| ad_out | output | 8 | Drive value of the multiplexed address/data lines |
| ad_oe | output | 1 | Output enable of the multiplexed address/data lines |
| a_mid | output | 8 | Address bits 15:8 |
| a_top | output | 4 | Address bits 19:16 in T1, status afterwards |

## Verification
The assertions assume that ready_in and hold_in are steady around each rising edge, and that the core presents a request only with req_valid and holds it until the accepting edge. The bench changes every input only on falling edges. It raises req_valid only after it has seen req_ready high, and it drops hold_in only while the block sits in hold. The bench drives reset pulses of three and of five cycles, both during bus hold. This exercises the filter on both sides of its threshold while the outputs can be seen.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 8;
    localparam int TOP_W  = 4;
    localparam int MID_W  = ADDR_W - DATA_W - TOP_W;
    localparam int SEG_W  = 2;
    localparam int OFS_W  = 16;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5,
        ST_HOLD = 3'd6
    } bus_st_e;

    typedef struct packed {
        logic              wr;
        logic              io;
        logic [SEG_W-1:0]  seg;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic              ale;
        logic              io_m;
        logic              rd_n;
        logic              wr_n;
        logic              dt_r;
        logic              den_n;
        logic              ad_oe;
        logic              hlda;
        logic [DATA_W-1:0] ad;
        logic [MID_W-1:0]  mid;
        logic [TOP_W-1:0]  top;
    } pin_set_t;

    function automatic pin_set_t idle_pins();
        pin_set_t p;
        p       = '0;
        p.rd_n  = 1'b1;
        p.wr_n  = 1'b1;
        p.den_n = 1'b1;
        p.dt_r  = 1'b1;
        return p;
    endfunction

    function automatic logic [ADDR_W-1:0] phys_addr(input logic [OFS_W-1:0] seg,
                                                    input logic [OFS_W-1:0] off);
        logic [ADDR_W-1:0] base;
        base = ADDR_W'(seg) << 4;
        return base + ADDR_W'(off);
    endfunction

    function automatic logic in_cycle(input bus_st_e st);
        return (st == ST_T1) || (st == ST_T2) || (st == ST_T3) ||
               (st == ST_TW) || (st == ST_T4);
    endfunction

    function automatic logic in_strobe(input bus_st_e st);
        return (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
    endfunction

    function automatic logic [TOP_W-1:0] status_bits(input logic [SEG_W-1:0] seg);
        return {{(TOP_W-SEG_W){1'b0}}, seg};
    endfunction

endpackage

// File: rtl/mbs_rst_filter.sv
module mbs_rst_filter #(
    parameter int RST_MIN = 4
) (
    input  logic clk,
    input  logic rst_pin,
    output logic rst_act
);
    localparam int CW = $clog2(RST_MIN + 1);
    localparam logic [CW-1:0] LAST = CW'(RST_MIN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_pin) begin
            cnt     <= '0;
            rst_act <= 1'b0;
        end else begin
            if (cnt != LAST)
                cnt <= cnt + 1'b1;
            if (cnt == LAST)
                rst_act <= 1'b1;
        end
    end
endmodule

// File: rtl/mbs_cycle_fsm.sv
module mbs_cycle_fsm
    import mbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_act,
    input  logic              hold_in,
    input  logic              ready_in,
    input  logic              req_valid,
    input  bus_req_t          req_in,
    input  logic [DATA_W-1:0] ad_in,
    output bus_st_e           state,
    output bus_req_t          cur,
    output logic [DATA_W-1:0] rdata,
    output logic              req_ready
);
    bus_st_e nxt;
    logic    xfer_end;

    assign req_ready = (state == ST_IDLE) && !hold_in && !rst_act;
    assign xfer_end  = ((state == ST_T3) || (state == ST_TW)) && ready_in;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (hold_in)
                    nxt = ST_HOLD;
                else if (req_valid)
                    nxt = ST_T1;
            end
            ST_T1:   nxt = ST_T2;
            ST_T2:   nxt = ST_T3;
            ST_T3,
            ST_TW:   nxt = ready_in ? ST_T4 : ST_TW;
            ST_T4:   nxt = hold_in ? ST_HOLD : ST_IDLE;
            ST_HOLD: nxt = hold_in ? ST_HOLD : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_act) begin
            state <= ST_IDLE;
            cur   <= '0;
            rdata <= '0;
        end else begin
            state <= nxt;
            if (req_ready && req_valid)
                cur <= req_in;
            if (xfer_end && !cur.wr)
                rdata <= ad_in;
        end
    end
endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
    import mbs_pkg::*;
(
    input  logic     rst_act,
    input  bus_st_e  state,
    input  bus_req_t cur,
    output pin_set_t pins
);
    always_comb begin
        pins = idle_pins();
        if (!rst_act) begin
            if (in_cycle(state)) begin
                pins.io_m = cur.io;
                pins.dt_r = cur.wr;
                pins.mid  = cur.addr[DATA_W +: MID_W];
                pins.top  = status_bits(cur.seg);
                if (cur.wr) begin
                    pins.ad    = cur.wdata;
                    pins.ad_oe = 1'b1;
                end
            end
            if (state == ST_T1) begin
                pins.ale   = 1'b1;
                pins.ad    = cur.addr[DATA_W-1:0];
                pins.ad_oe = 1'b1;
                pins.top   = cur.addr[ADDR_W-1 -: TOP_W];
            end
            if (in_strobe(state)) begin
                pins.rd_n  = cur.wr;
                pins.wr_n  = !cur.wr;
                pins.den_n = 1'b0;
            end
            if (state == ST_HOLD)
                pins.hlda = 1'b1;
        end
    end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int           RST_MIN  = 4,
    parameter logic [15:0]  RESET_CS = 16'hFFFF,
    parameter logic [15:0]  RESET_IP = 16'h0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_in,
    input  logic              ready_in,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ad_in,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] boot_addr,
    output logic              ale,
    output logic              io_m,
    output logic              rd_n,
    output logic              wr_n,
    output logic              dt_r,
    output logic              den_n,
    output logic              hlda,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [MID_W-1:0]  a_mid,
    output logic [TOP_W-1:0]  a_top
);
    logic     rst_act;
    bus_st_e  state;
    bus_req_t req_in;
    bus_req_t cur;
    pin_set_t pins;

    assign req_in = '{wr: req_write, io: req_io, seg: req_seg,
                      addr: req_addr, wdata: req_wdata};

    mbs_rst_filter #(.RST_MIN(RST_MIN)) u_rst (
        .clk     (clk),
        .rst_pin (rst),
        .rst_act (rst_act)
    );

    mbs_cycle_fsm u_fsm (
        .clk       (clk),
        .rst_act   (rst_act),
        .hold_in   (hold_in),
        .ready_in  (ready_in),
        .req_valid (req_valid),
        .req_in    (req_in),
        .ad_in     (ad_in),
        .state     (state),
        .cur       (cur),
        .rdata     (rdata),
        .req_ready (req_ready)
    );

    mbs_pin_drive u_pins (
        .rst_act (rst_act),
        .state   (state),
        .cur     (cur),
        .pins    (pins)
    );

    assign done      = (state == ST_T4) && !rst_act;
    assign boot_addr = phys_addr(RESET_CS, RESET_IP);
    assign ale       = pins.ale;
    assign io_m      = pins.io_m;
    assign rd_n      = pins.rd_n;
    assign wr_n      = pins.wr_n;
    assign dt_r      = pins.dt_r;
    assign den_n     = pins.den_n;
    assign hlda      = pins.hlda;
    assign ad_out    = pins.ad;
    assign ad_oe     = pins.ad_oe;
    assign a_mid     = pins.mid;
    assign a_top     = pins.top;
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
    input logic clk,
    input logic rst_act,
    input logic ready_in,
    input logic ale,
    input logic io_m,
    input logic rd_n,
    input logic wr_n,
    input logic den_n,
    input logic ad_oe,
    input logic hlda,
    input logic done
);
    // R7
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst_act)
        !(!rd_n && !wr_n));

    // R7
    den_match_chk: assert property (@(posedge clk) disable iff (rst_act)
        den_n == (rd_n && wr_n));

    // R3
    ale_drive_chk: assert property (@(posedge clk) disable iff (rst_act)
        ale |-> ad_oe);

    // R4
    iom_hold_chk: assert property (@(posedge clk) disable iff (rst_act)
        ale |=> $stable(io_m));

    // R5
    rd_float_chk: assert property (@(posedge clk) disable iff (rst_act)
        !rd_n |-> !ad_oe);

    // R6
    wr_drive_chk: assert property (@(posedge clk) disable iff (rst_act)
        !wr_n |-> ad_oe);

    // R9
    rd_wait_chk: assert property (@(posedge clk) disable iff (rst_act)
        (!rd_n && !$past(rd_n) && !ready_in) |=> !rd_n);

    // R9
    wr_wait_chk: assert property (@(posedge clk) disable iff (rst_act)
        (!wr_n && !$past(wr_n) && !ready_in) |=> !wr_n);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst_act)
        done |=> !done);

    // R11
    hold_quiet_chk: assert property (@(posedge clk) disable iff (rst_act)
        hlda |-> (rd_n && wr_n && !ad_oe && !ale));
endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
    .clk      (clk),
    .rst_act  (rst_act),
    .ready_in (ready_in),
    .ale      (ale),
    .io_m     (io_m),
    .rd_n     (rd_n),
    .wr_n     (wr_n),
    .den_n    (den_n),
    .ad_oe    (ad_oe),
    .hlda     (hlda),
    .done     (done)
);

// File: tb/mux_bus_seq_test.sv
`timescale 1ns/1ps
module mux_bus_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold_in = 1'b0;
    logic        ready_in = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_io = 1'b0;
    logic [1:0]  req_seg = 2'd0;
    logic [19:0] req_addr = 20'd0;
    logic [7:0]  req_wdata = 8'd0;
    logic [7:0]  ad_in = 8'd0;
    logic        req_ready, done, ale, io_m, rd_n, wr_n, dt_r, den_n, hlda, ad_oe;
    logic [7:0]  rdata, ad_out, a_mid;
    logic [19:0] boot_addr;
    logic [3:0]  a_top;

    int errs = 0;
    int total = 0;
    bit finished = 1'b0;
    int exp_q[$];

    always #5 clk = ~clk;

    mux_bus_seq uut (
        .clk(clk), .rst(rst), .hold_in(hold_in), .ready_in(ready_in),
        .req_valid(req_valid), .req_write(req_write), .req_io(req_io),
        .req_seg(req_seg), .req_addr(req_addr), .req_wdata(req_wdata),
        .ad_in(ad_in), .req_ready(req_ready), .done(done), .rdata(rdata),
        .boot_addr(boot_addr), .ale(ale), .io_m(io_m), .rd_n(rd_n),
        .wr_n(wr_n), .dt_r(dt_r), .den_n(den_n), .hlda(hlda),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_mid(a_mid), .a_top(a_top)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic chk_quiet(input string tag);
        chk_eq({tag, " ale"}, ale, 0);
        chk_eq({tag, " rd_n"}, rd_n, 1);
        chk_eq({tag, " wr_n"}, wr_n, 1);
        chk_eq({tag, " den_n"}, den_n, 1);
        chk_eq({tag, " ad_oe"}, ad_oe, 0);
    endtask

    // scoreboard monitor: R10 completion data
    always @(negedge clk) begin
        if (done && !finished) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected done", 1, 0);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e >= 0)
                    chk_eq("R10 read data", int'(rdata), e);
                else
                    total++;
            end
        end
    end

    task automatic run_cycle(input bit wr, input bit io, input logic [1:0] seg,
                             input logic [19:0] addr, input logic [7:0] wd,
                             input logic [7:0] mem, input int waits, input bit hold_mid);
        @(negedge clk);
        chk_eq("R3 req_ready idle", req_ready, 1);
        req_write = wr; req_io = io; req_seg = seg;
        req_addr = addr; req_wdata = wd; req_valid = 1'b1;
        ready_in = 1'b1;
        @(negedge clk); // T1
        req_valid = 1'b0;
        chk_eq("R3 ale", ale, 1);
        chk_eq("R3 ad_out addr", ad_out, addr[7:0]);
        chk_eq("R3 a_mid", a_mid, addr[15:8]);
        chk_eq("R3 a_top", a_top, addr[19:16]);
        chk_eq("R3 ad_oe", ad_oe, 1);
        chk_eq("R4 io_m T1", io_m, io);
        chk_eq(wr ? "R6 dt_r" : "R5 dt_r", dt_r, wr);
        ready_in = (waits == 0);
        if (hold_mid) hold_in = 1'b1;
        @(negedge clk); // T2
        if (wr) begin
            chk_eq("R6 wr_n", wr_n, 0);
            chk_eq("R6 ad_out data", ad_out, wd);
            chk_eq("R6 ad_oe", ad_oe, 1);
        end else begin
            chk_eq("R5 rd_n", rd_n, 0);
            chk_eq("R5 ad_oe float", ad_oe, 0);
        end
        chk_eq("R7 den_n", den_n, 0);
        chk_eq("R8 status", a_top, {2'b00, seg});
        chk_eq("R3 ale low", ale, 0);
        ad_in = mem;
        @(negedge clk); // T3
        exp_q.push_back(wr ? -1 : int'(mem));
        chk_eq(wr ? "R6 wr_n T3" : "R5 rd_n T3", wr ? wr_n : rd_n, 0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk); // Tw
            chk_eq("R9 strobe in wait", wr ? wr_n : rd_n, 0);
            chk_eq("R9 no done in wait", done, 0);
            if (i == waits - 1) ready_in = 1'b1;
        end
        @(negedge clk); // T4
        chk_eq("R7 rd_n T4", rd_n, 1);
        chk_eq("R7 wr_n T4", wr_n, 1);
        chk_eq("R7 den_n T4", den_n, 1);
        chk_eq("R4 io_m T4", io_m, io);
        chk_eq("R8 status T4", a_top, {2'b00, seg});
        chk_eq("R10 done", done, 1);
        if (wr) chk_eq("R6 ad_oe T4", ad_oe, 1);
        if (hold_mid) chk_eq("R11 no hlda before end", hlda, 0);
        ad_in = ~mem;
        @(negedge clk); // idle or hold
        chk_eq("R10 done single", done, 0);
        if (hold_mid) begin
            chk_eq("R11 hlda", hlda, 1);
            chk_eq("R11 req_ready", req_ready, 0);
            chk_quiet("R11 hold");
        end else begin
            chk_eq("R4 io_m idle", io_m, 0);
            chk_eq("R3 ale idle", ale, 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end

    initial begin
        // initial reset of 6 cycles
        repeat (5) @(negedge clk);
        chk_quiet("R1 in reset");
        chk_eq("R1 req_ready reset", req_ready, 0);
        chk_eq("R1 hlda reset", hlda, 0);
        chk_eq("R1 done reset", done, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 req_ready after reset", req_ready, 1);
        chk_eq("R2 boot_addr", boot_addr, 20'hFFFF0);

        // reads and writes, memory and I/O, with and without waits
        run_cycle(1'b0, 1'b0, 2'd1, 20'hA5C3E, 8'h00, 8'h5A, 0, 1'b0);
        run_cycle(1'b1, 1'b0, 2'd2, 20'h3F12C, 8'hC7, 8'h00, 0, 1'b0);
        run_cycle(1'b0, 1'b1, 2'd3, 20'h0047B, 8'h00, 8'h96, 3, 1'b0);
        run_cycle(1'b1, 1'b1, 2'd0, 20'hFFFF0, 8'h3D, 8'h00, 2, 1'b0);
        run_cycle(1'b0, 1'b0, 2'd2, 20'h80001, 8'h00, 8'hE1, 1, 1'b0);

        // hold requested in the middle of a cycle (R11)
        run_cycle(1'b0, 1'b0, 2'd1, 20'h12345, 8'h00, 8'h77, 1, 1'b1);
        hold_in = 1'b0;
        @(negedge clk);
        chk_eq("R11 hlda released", hlda, 0);
        chk_eq("R11 req_ready released", req_ready, 1);

        // hold wins over a simultaneous request; short reset ignored (R1)
        hold_in = 1'b1;
        req_valid = 1'b1; req_write = 1'b0; req_addr = 20'h55555;
        @(negedge clk);
        chk_eq("R11 hold priority hlda", hlda, 1);
        chk_eq("R11 hold priority ale", ale, 0);
        req_valid = 1'b0;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_eq("R1 short reset ignored", hlda, 1);
        end
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 after short reset", hlda, 1);

        // a long reset takes effect after the fourth edge
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk_eq("R1 three edges not yet", hlda, 1);
        @(negedge clk);
        chk_eq("R1 reset effective", hlda, 0);
        chk_eq("R1 reset req_ready", req_ready, 0);
        hold_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R1 idle after reset", req_ready, 1);
        chk_eq("R1 hlda after reset", hlda, 0);

        run_cycle(1'b0, 1'b1, 2'd0, 20'h0FF80, 8'h00, 8'h2B, 0, 1'b0);
        repeat (2) @(negedge clk);
        chk_eq("R10 queue drained", exp_q.size(), 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end
endmodule